// File: doc/BRIEF.md
# Colour Key Window Detector

This block decides, one pixel at a time, whether a Y/Cb/Cr sample lies inside a programmable box in colour space. Each of the three colour components has its own lower limit, upper limit and an override bit that takes the component out of the decision. Only the top eight bits of each sample are compared. A sample can be wider than eight bits. Its low-order bits never change the result.

The block produces one flag per component and a combined flag that is high only when all three components agree. Both are registered on the pixel clock. A downstream stage can therefore use the combined flag to choose between two pixel sources, and it can use the per-component flags to see which axis rejected a colour. Writing the limits into storage is not part of this block, and neither is acting on the flag.

Top module: `key_win_top`

## Requirements
- R1: Only the eight most significant bits of each SAMPLE_W-bit sample take part in the comparison; the lower SAMPLE_W-8 bits have no effect on any output.
- R2: The lower limit is exclusive: a component whose upper eight bits equal its lower limit does not match, and one bit above the limit does match (given the upper limit allows it).
- R3: The upper limit is inclusive: a component whose upper eight bits equal its upper limit matches, and one above it does not.
- R4: Each component uses only its own limits; changing the limits of one component never changes another component's flag.
- R5: `key_dis` bit 0 (Y), bit 1 (Cb) and bit 2 (Cr) take the matching component out of the decision: while its bit is 1, that component's flag in `ch_match` (same bit order) reads 1 whatever its sample and limits.
- R6: `key_match` is 1 exactly when all three bits of `ch_match` are 1.
- R7: An enabled component whose lower limit is greater than or equal to its upper limit never matches.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge, a latency of one cycle.
- R9: While `rst_n` is low, `ch_match` and `key_match` are 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| y_smp | input | SAMPLE_W | Luma sample |
| cb_smp | input | SAMPLE_W | Blue-difference sample |
| cr_smp | input | SAMPLE_W | Red-difference sample |
| y_min | input | KEY_W | Luma lower limit (exclusive) |
| y_max | input | KEY_W | Luma upper limit (inclusive) |
| cb_min | input | KEY_W | Cb lower limit (exclusive) |
| cb_max | input | KEY_W | Cb upper limit (inclusive) |
| cr_min | input | KEY_W | Cr lower limit (exclusive) |
| cr_max | input | KEY_W | Cr upper limit (inclusive) |
| key_dis | input | 3 | Per-component override: bit0 Y, bit1 Cb, bit2 Cr |
| ch_match | output | 3 | Registered per-component match, same bit order |
| key_match | output | 1 | Registered AND of the three component matches |

## Verification
The checker's properties assume that every data, limit and override input holds a known 0/1 value at each rising edge after reset is released, because each property compares the outputs with those inputs one cycle earlier. The bench drives every input to a defined value at time zero. It changes inputs only on the falling edge, so each value is stable for a full cycle around the sampling edge. It also holds the inputs at defined values while reset is low, so the first cycle after release refers to known stimulus.

// File: rtl/key_win_pkg.sv
package key_win_pkg;

    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        CH_Y  = 2'd0,
        CH_CB = 2'd1,
        CH_CR = 2'd2
    } chan_e;

    typedef struct packed {
        logic [NUM_CH-1:0] ch_hit;
        logic              all_hit;
    } key_state_t;

endpackage

// File: rtl/key_win_cmp.sv
module key_win_cmp #(
    parameter int SAMPLE_W = 10,
    parameter int KEY_W    = 8
) (
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [KEY_W-1:0]    lo,
    input  logic [KEY_W-1:0]    hi,
    input  logic                dis,
    output logic                hit
);
    localparam int DROP = SAMPLE_W - KEY_W;

    logic [SAMPLE_W-1:0] top_bits;
    logic                above_lo;
    logic                below_hi;

    always_comb begin
        // Discard the low-order bits; only the key-width MSBs remain.
        top_bits = smp >> DROP;
        above_lo = top_bits >  SAMPLE_W'(lo);
        below_hi = top_bits <= SAMPLE_W'(hi);
        hit      = dis | (above_lo & below_hi);
    end
endmodule

// File: rtl/key_win_top.sv
module key_win_top
    import key_win_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int KEY_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] y_smp,
    input  logic [SAMPLE_W-1:0] cb_smp,
    input  logic [SAMPLE_W-1:0] cr_smp,
    input  logic [KEY_W-1:0]    y_min,
    input  logic [KEY_W-1:0]    y_max,
    input  logic [KEY_W-1:0]    cb_min,
    input  logic [KEY_W-1:0]    cb_max,
    input  logic [KEY_W-1:0]    cr_min,
    input  logic [KEY_W-1:0]    cr_max,
    input  logic [2:0]          key_dis,
    output logic [2:0]          ch_match,
    output logic                key_match
);
    logic [SAMPLE_W-1:0] smp_a [NUM_CH];
    logic [KEY_W-1:0]    lo_a  [NUM_CH];
    logic [KEY_W-1:0]    hi_a  [NUM_CH];
    logic [NUM_CH-1:0]   hit_w;

    key_state_t state_d;
    key_state_t state_q;

    always_comb begin
        smp_a[CH_Y]  = y_smp;
        smp_a[CH_CB] = cb_smp;
        smp_a[CH_CR] = cr_smp;
        lo_a[CH_Y]   = y_min;
        lo_a[CH_CB]  = cb_min;
        lo_a[CH_CR]  = cr_min;
        hi_a[CH_Y]   = y_max;
        hi_a[CH_CB]  = cb_max;
        hi_a[CH_CR]  = cr_max;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        key_win_cmp #(
            .SAMPLE_W(SAMPLE_W),
            .KEY_W   (KEY_W)
        ) i_cmp (
            .smp(smp_a[c]),
            .lo (lo_a[c]),
            .hi (hi_a[c]),
            .dis(key_dis[c]),
            .hit(hit_w[c])
        );
    end

    always_comb begin
        state_d         = state_q;
        state_d.ch_hit  = hit_w;
        state_d.all_hit = &hit_w;
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign ch_match  = state_q.ch_hit;
    assign key_match = state_q.all_hit;
endmodule

// File: rtl/key_win_chk.sv
module key_win_chk #(
    parameter int SAMPLE_W = 10,
    parameter int KEY_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] y_smp,
    input logic [SAMPLE_W-1:0] cb_smp,
    input logic [SAMPLE_W-1:0] cr_smp,
    input logic [KEY_W-1:0]    y_min,
    input logic [KEY_W-1:0]    y_max,
    input logic [KEY_W-1:0]    cb_min,
    input logic [KEY_W-1:0]    cb_max,
    input logic [KEY_W-1:0]    cr_min,
    input logic [KEY_W-1:0]    cr_max,
    input logic [2:0]          key_dis,
    input logic [2:0]          ch_match,
    input logic                key_match
);
    localparam int DROP = SAMPLE_W - KEY_W;

    logic [SAMPLE_W-1:0] msb_v [3];
    logic [SAMPLE_W-1:0] lo_v  [3];
    logic [SAMPLE_W-1:0] hi_v  [3];

    always_comb begin
        msb_v[0] = y_smp  >> DROP;
        msb_v[1] = cb_smp >> DROP;
        msb_v[2] = cr_smp >> DROP;
        lo_v[0]  = SAMPLE_W'(y_min);
        lo_v[1]  = SAMPLE_W'(cb_min);
        lo_v[2]  = SAMPLE_W'(cr_min);
        hi_v[0]  = SAMPLE_W'(y_max);
        hi_v[1]  = SAMPLE_W'(cb_max);
        hi_v[2]  = SAMPLE_W'(cr_max);
    end

    // R9: reset clears both outputs on the following edge
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (ch_match == 3'b000 && key_match == 1'b0));

    // R6: combined flag agrees with the component flags
    assert_and_combine_R6: assert property (@(posedge clk) disable iff (!rst_n)
        key_match == (ch_match == 3'b111));

    for (genvar c = 0; c < 3; c++) begin : g_prop
        // R5: override forces the component flag high one cycle later
        assert_dis_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
            key_dis[c] |=> ch_match[c]);

        // R7: empty window never matches while enabled
        assert_empty_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!key_dis[c] && lo_v[c] >= hi_v[c]) |=> !ch_match[c]);

        // R2 R3 R8: enabled window decision appears one cycle later
        assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !key_dis[c] |=> ch_match[c] ==
                ($past(msb_v[c]) > $past(lo_v[c]) && $past(msb_v[c]) <= $past(hi_v[c])));
    end
endmodule

bind key_win_top key_win_chk #(
    .SAMPLE_W(SAMPLE_W),
    .KEY_W   (KEY_W)
) i_key_win_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .y_smp    (y_smp),
    .cb_smp   (cb_smp),
    .cr_smp   (cr_smp),
    .y_min    (y_min),
    .y_max    (y_max),
    .cb_min   (cb_min),
    .cb_max   (cb_max),
    .cr_min   (cr_min),
    .cr_max   (cr_max),
    .key_dis  (key_dis),
    .ch_match (ch_match),
    .key_match(key_match)
);

// File: tb/test_key_win_top.sv
module test_key_win_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 10;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] y_smp = '0, cb_smp = '0, cr_smp = '0;
    logic [KW-1:0] y_min = '0, y_max = '0, cb_min = '0, cb_max = '0, cr_min = '0, cr_max = '0;
    logic [2:0]    key_dis = '0;
    logic [2:0]    ch_match;
    logic          key_match;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R9";
    logic [2:0] exp_ch = '0;
    logic       exp_all = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_win_top #(.SAMPLE_W(SW), .KEY_W(KW)) i_key_win_top (
        .clk(clk), .rst_n(rst_n),
        .y_smp(y_smp), .cb_smp(cb_smp), .cr_smp(cr_smp),
        .y_min(y_min), .y_max(y_max), .cb_min(cb_min), .cb_max(cb_max),
        .cr_min(cr_min), .cr_max(cr_max), .key_dis(key_dis),
        .ch_match(ch_match), .key_match(key_match)
    );

    function automatic logic ref_hit(int s, int lo, int hi, logic dis);
        int top;
        top = s / (1 << (SW - KW));
        return dis || (top > lo && top <= hi);
    endfunction

    // Reference for the values presented at the coming rising edge.
    task automatic predict();
        if (!rst_n) begin
            exp_ch = '0;
        end else begin
            exp_ch[0] = ref_hit(int'(y_smp),  int'(y_min),  int'(y_max),  key_dis[0]);
            exp_ch[1] = ref_hit(int'(cb_smp), int'(cb_min), int'(cb_max), key_dis[1]);
            exp_ch[2] = ref_hit(int'(cr_smp), int'(cr_min), int'(cr_max), key_dis[2]);
        end
        exp_all = rst_n && (exp_ch == 3'b111);
    endtask

    // Wait for the edge, then compare at the falling edge.
    task automatic step();
        predict();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        checks++;
        if (ch_match !== exp_ch) begin
            errors++;
            $display("FAIL %s ch_match actual %b expected %b", tag, ch_match, exp_ch);
        end
        checks++;
        if (key_match !== exp_all) begin
            errors++;
            $display("FAIL %s key_match actual %b expected %b", tag, key_match, exp_all);
        end
    endtask

    task automatic set_win(int ylo, int yhi, int blo, int bhi, int rlo, int rhi);
        y_min = KW'(ylo); y_max = KW'(yhi);
        cb_min = KW'(blo); cb_max = KW'(bhi);
        cr_min = KW'(rlo); cr_max = KW'(rhi);
    endtask

    task automatic set_px(int ys, int bs, int rs);
        y_smp = SW'(ys); cb_smp = SW'(bs); cr_smp = SW'(rs);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R9: reset state
        tag = "R9";
        set_win(10, 200, 10, 200, 10, 200);
        set_px(100 * 4, 100 * 4, 100 * 4);
        step(); step();
        @(negedge clk);
        rst_n = 1'b1;

        // R8: a match appears one cycle after it is presented
        tag = "R8";
        step();
        set_px(5 * 4, 100 * 4, 100 * 4);
        step();
        set_px(100 * 4, 100 * 4, 100 * 4);
        step();

        // R1: low two bits vary, upper byte fixed at the boundaries
        tag = "R1";
        set_win(50, 60, 50, 60, 50, 60);
        for (int k = 0; k < 4; k++) begin
            set_px(50 * 4 + k, 60 * 4 + k, 51 * 4 + k);
            step();
        end

        // R2: exclusive lower bound
        tag = "R2";
        set_win(50, 60, 50, 60, 50, 60);
        set_px(50 * 4, 51 * 4, 51 * 4); step();
        set_px(51 * 4, 51 * 4, 51 * 4); step();
        set_px(0, 0, 0); set_win(0, 255, 0, 255, 0, 255); step();

        // R3: inclusive upper bound
        tag = "R3";
        set_win(50, 60, 50, 60, 50, 60);
        set_px(60 * 4 + 3, 60 * 4, 60 * 4); step();
        set_px(61 * 4, 60 * 4, 60 * 4); step();
        set_win(0, 255, 0, 255, 0, 255);
        set_px(1023, 1023, 1023); step();

        // R4: changing one component's window leaves others alone
        tag = "R4";
        set_win(10, 20, 30, 40, 50, 60);
        set_px(15 * 4, 35 * 4, 55 * 4); step();
        cb_min = 8'd36; step();
        y_max = 8'd12; step();
        cr_min = 8'd0; cr_max = 8'd255; step();

        // R5: override each component in turn with a failing sample
        tag = "R5";
        set_win(10, 20, 10, 20, 10, 20);
        set_px(200 * 4, 200 * 4, 200 * 4);
        for (int b = 0; b < 8; b++) begin
            key_dis = 3'(b);
            step();
        end
        key_dis = 3'b000;

        // R6: combined flag across single-component failures
        tag = "R6";
        set_win(10, 20, 10, 20, 10, 20);
        set_px(15 * 4, 15 * 4, 15 * 4); step();
        set_px(25 * 4, 15 * 4, 15 * 4); step();
        set_px(15 * 4, 25 * 4, 15 * 4); step();
        set_px(15 * 4, 15 * 4, 25 * 4); step();

        // R7: empty and equal windows
        tag = "R7";
        set_win(40, 40, 90, 30, 255, 255);
        set_px(40 * 4, 60 * 4, 1023); step();
        set_px(41 * 4, 31 * 4, 0); step();
        set_win(40, 40, 41, 42, 255, 0);
        set_px(40 * 4, 42 * 4, 128 * 4); step();

        // R9: reset mid-stream clears a live match
        tag = "R9";
        set_win(0, 255, 0, 255, 0, 255);
        set_px(9 * 4, 9 * 4, 9 * 4);
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();

        // R8: pseudo-random traffic against the reference every cycle
        tag = "R8";
        for (int n = 0; n < 400; n++) begin
            set_px(int'($urandom_range(1023)), int'($urandom_range(1023)), int'($urandom_range(1023)));
            if (n % 8 == 0) begin
                set_win(int'($urandom_range(255)), int'($urandom_range(255)),
                        int'($urandom_range(255)), int'($urandom_range(255)),
                        int'($urandom_range(255)), int'($urandom_range(255)));
                key_dis = 3'($urandom_range(7));
            end
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule